// File: doc/BRIEF.md
# BCD Calendar Clock with Hundredths

This block keeps time of day and calendar date in packed BCD, advancing once per pulse of a 100 Hz tick enable. Eight 8-bit registers form a single 64-bit image: hundredths, seconds, minutes, hours, day of week, date, month and year, in that order from the least significant byte up. The image is presented on the output at all times, so an access controller can sample it or shift it out serially.

The access controller writes the clock by presenting a whole 64-bit image with a one-cycle load strobe; all eight registers are replaced together. Two control bits live inside the data registers: the hours register holds the 12/24-hour selector, and the day register holds a halt bit that freezes counting. Month lengths and February in leap years are handled for two-digit years.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the image reads hundredths 00, seconds 00, minutes 00, hours 00 in 24-hour mode, day 1, date 01, month 01, year 00, with the halt bit clear, so `regs_o` = 64'h0001_0101_0000_0000.
- R2: Byte k of `regs_o` (bits 8k+7..8k) holds, for k = 0..7, hundredths, seconds, minutes, hours, day, date, month, year. A cycle with `load_i` high makes `regs_o` equal to `load_data_i` (with R3 bits cleared) after that clock edge.
- R3: Bits that carry no meaning always read 0: seconds and minutes bit 7, hours bit 6, day bits 7, 6, 4 and 3, date bits 7:6, month bits 7:5. Loading all ones gives 64'hFF1F_3F27_BF7F_7FFF.
- R4: When `load_i` and `tick_i` are high in the same cycle, the loaded image is kept unchanged; the tick is lost.
- R5: Each accepted tick adds one hundredth; hundredths count 00..99, seconds and minutes 00..59, each wrap carrying into the next field.
- R6: With hours bit 7 = 0 the hours count 00..23 in BCD (bit 5 is the twenties digit); the 23-to-00 wrap advances day of week and date.
- R7: With hours bit 7 = 1 the hours field bits 4:0 count 12, 01, ..., 11 in BCD and bit 5 is PM (1). Going from 11 to 12 toggles PM; the 11 PM to 12 AM step advances day and date. The mode bit only changes by a load.
- R8: Day of week (day bits 2:0) counts 1..7 and wraps to 1 on each day carry.
- R9: The date wraps to 01 and carries into the month after 30 for months 04, 06, 09, 11 and after 31 for 01, 03, 05, 07, 08, 10, 12.
- R10: In month 02 the date wraps after 29 when the year is divisible by 4 (00 included) and after 28 otherwise.
- R11: Month counts 01..12 and the 12-to-01 wrap advances the year; the year counts 00..99 and wraps to 00.
- R12: While day bit 5 is 1 ticks are ignored and the image holds; with `tick_i` low and no load the image also holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz advance enable, one cycle per hundredth |
| load_i | input | 1 | Load strobe for the full image |
| load_data_i | input | 64 | Image written on a load |
| regs_o | output | 64 | Current register image |

## Verification
The hardest states to reach from the ports are the carry chains that cross the date, month and year, since ticking there from reset would take years of simulated hundredths. The bench instead loads an image set to the last hundredth before the boundary and gives one tick, and it sweeps this over every month, every two-digit year for February, every hour in both modes and every weekday, predicting the result with its own arithmetic model of the calendar.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int IMG_W    = REG_W * NUM_REGS;

  localparam int IDX_HUND = 0;
  localparam int IDX_SEC  = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_HOUR = 3;
  localparam int IDX_DAY  = 4;
  localparam int IDX_DATE = 5;
  localparam int IDX_MON  = 6;
  localparam int IDX_YEAR = 7;

  localparam int HOUR_MODE_BIT = 7;
  localparam int HOUR_PM_BIT   = 5;
  localparam int DAY_HALT_BIT  = 5;
  localparam int HALT_IMG_BIT  = IDX_DAY * REG_W + DAY_HALT_BIT;

  localparam logic [REG_W-1:0] MASK_HUND = 8'hFF;
  localparam logic [REG_W-1:0] MASK_SEC  = 8'h7F;
  localparam logic [REG_W-1:0] MASK_MIN  = 8'h7F;
  localparam logic [REG_W-1:0] MASK_HOUR = 8'hBF;
  localparam logic [REG_W-1:0] MASK_DAY  = 8'h27;
  localparam logic [REG_W-1:0] MASK_DATE = 8'h3F;
  localparam logic [REG_W-1:0] MASK_MON  = 8'h1F;
  localparam logic [REG_W-1:0] MASK_YEAR = 8'hFF;
  localparam logic [REG_W-1:0] MASK_DOW  = 8'h07;

  localparam logic [IMG_W-1:0] IMG_MASK = {MASK_YEAR, MASK_MON, MASK_DATE, MASK_DAY,
                                           MASK_HOUR, MASK_MIN, MASK_SEC, MASK_HUND};

  // two-digit BCD increment; carry out of the tens digit is dropped
  function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic bcd_leap(input logic [REG_W-1:0] yr);
    logic tens_even;
    logic r;
    tens_even = ~yr[4];
    case (yr[3:0])
      4'd0, 4'd4, 4'd8: r = tens_even;
      4'd2, 4'd6:       r = ~tens_even;
      default:          r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [REG_W-1:0] month_last(input logic [REG_W-1:0] mon,
                                                  input logic [REG_W-1:0] yr);
    logic [REG_W-1:0] r;
    case (mon)
      8'h02:                      r = bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bcd_wrap_cnt.sv
module bcd_wrap_cnt
  import bcd_cal_pkg::*;
#(
  parameter logic [REG_W-1:0] LO  = 8'h00,
  parameter logic [REG_W-1:0] HI  = 8'h59,
  parameter logic [REG_W-1:0] RST = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ld_i,
  input  logic [REG_W-1:0] ld_val_i,
  output logic [REG_W-1:0] q_o,
  output logic             wrap_o
);
  logic [REG_W-1:0] q_q;
  logic             at_top;

  assign at_top = (q_q == HI);
  assign wrap_o = en_i & at_top;
  assign q_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= RST;
    else if (ld_i) q_q <= ld_val_i;
    else if (en_i) q_q <= at_top ? LO : bcd_inc(q_q);
  end
endmodule

// File: rtl/bcd_hour_cnt.sv
module bcd_hour_cnt
  import bcd_cal_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ld_i,
  input  logic [REG_W-1:0] ld_val_i,
  output logic [REG_W-1:0] q_o,
  output logic             wrap_o
);
  logic [REG_W-1:0] q_q;
  logic [REG_W-1:0] nxt;
  logic             mode12, pm;
  logic [REG_W-1:0] h12, h24;
  logic             day_end;

  assign mode12 = q_q[HOUR_MODE_BIT];
  assign pm     = q_q[HOUR_PM_BIT];
  assign h12    = {3'b000, q_q[4:0]};
  assign h24    = {2'b00, q_q[5:0]};

  always_comb begin
    nxt     = q_q;
    day_end = 1'b0;
    if (mode12) begin
      if (h12 == 8'h12) begin
        nxt = {1'b1, 1'b0, pm, 5'h01};
      end else if (h12 == 8'h11) begin
        nxt     = {1'b1, 1'b0, ~pm, 5'h12};
        day_end = pm;
      end else begin
        nxt = {1'b1, 1'b0, pm, bcd_inc(h12)[4:0]};
      end
    end else begin
      if (h24 >= 8'h23) begin
        nxt     = 8'h00;
        day_end = 1'b1;
      end else begin
        nxt = {2'b00, bcd_inc(h24)[5:0]};
      end
    end
  end

  assign wrap_o = en_i & day_end;
  assign q_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= 8'h00;
    else if (ld_i) q_q <= ld_val_i;
    else if (en_i) q_q <= nxt;
  end
endmodule

// File: rtl/bcd_date_cnt.sv
module bcd_date_cnt
  import bcd_cal_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ld_i,
  input  logic [REG_W-1:0] ld_val_i,
  input  logic [REG_W-1:0] mon_i,
  input  logic [REG_W-1:0] year_i,
  output logic [REG_W-1:0] q_o,
  output logic             wrap_o
);
  logic [REG_W-1:0] q_q;
  logic [REG_W-1:0] last;
  logic             at_end;

  assign last   = month_last(mon_i, year_i);
  assign at_end = (q_q >= last);  // BCD order matches numeric order
  assign wrap_o = en_i & at_end;
  assign q_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= 8'h01;
    else if (ld_i) q_q <= ld_val_i;
    else if (en_i) q_q <= at_end ? 8'h01 : bcd_inc(q_q);
  end
endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
  import bcd_cal_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [IMG_W-1:0] load_data_i,
  output logic [IMG_W-1:0] regs_o
);
  localparam int TIME_CNTS = 3;  // hundredths, seconds, minutes

  logic [IMG_W-1:0]                ld_img;
  logic                            halt_q;
  logic                            run_en;
  logic [TIME_CNTS:0]              tm_en;
  logic [TIME_CNTS-1:0][REG_W-1:0] tm_q;
  logic [REG_W-1:0]                hour_q, dow_q, date_q, mon_q, year_q;
  logic                            day_carry, date_wrap, mon_wrap;
  logic                            unused_dow_wrap, unused_year_wrap;

  assign ld_img   = load_data_i & IMG_MASK;
  assign run_en   = tick_i & ~halt_q & ~load_i;
  assign tm_en[0] = run_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     halt_q <= 1'b0;
    else if (load_i) halt_q <= load_data_i[HALT_IMG_BIT];
  end

  for (genvar gi = 0; gi < TIME_CNTS; gi++) begin : g_time
    bcd_wrap_cnt #(
      .LO (8'h00),
      .HI ((gi == IDX_HUND) ? 8'h99 : 8'h59),
      .RST(8'h00)
    ) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (tm_en[gi]),
      .ld_i    (load_i),
      .ld_val_i(ld_img[gi*REG_W +: REG_W]),
      .q_o     (tm_q[gi]),
      .wrap_o  (tm_en[gi+1])
    );
  end

  bcd_hour_cnt u_hour (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tm_en[TIME_CNTS]),
    .ld_i    (load_i),
    .ld_val_i(ld_img[IDX_HOUR*REG_W +: REG_W]),
    .q_o     (hour_q),
    .wrap_o  (day_carry)
  );

  bcd_wrap_cnt #(.LO(8'h01), .HI(8'h07), .RST(8'h01)) u_dow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (day_carry),
    .ld_i    (load_i),
    .ld_val_i(ld_img[IDX_DAY*REG_W +: REG_W] & MASK_DOW),
    .q_o     (dow_q),
    .wrap_o  (unused_dow_wrap)
  );

  bcd_date_cnt u_date (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (day_carry),
    .ld_i    (load_i),
    .ld_val_i(ld_img[IDX_DATE*REG_W +: REG_W]),
    .mon_i   (mon_q),
    .year_i  (year_q),
    .q_o     (date_q),
    .wrap_o  (date_wrap)
  );

  bcd_wrap_cnt #(.LO(8'h01), .HI(8'h12), .RST(8'h01)) u_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (date_wrap),
    .ld_i    (load_i),
    .ld_val_i(ld_img[IDX_MON*REG_W +: REG_W]),
    .q_o     (mon_q),
    .wrap_o  (mon_wrap)
  );

  bcd_wrap_cnt #(.LO(8'h00), .HI(8'h99), .RST(8'h00)) u_year (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mon_wrap),
    .ld_i    (load_i),
    .ld_val_i(ld_img[IDX_YEAR*REG_W +: REG_W]),
    .q_o     (year_q),
    .wrap_o  (unused_year_wrap)
  );

  assign regs_o = {year_q, mon_q, date_q,
                   {2'b00, halt_q, 2'b00, dow_q[2:0]},
                   hour_q, tm_q[IDX_MIN], tm_q[IDX_SEC], tm_q[IDX_HUND]};
endmodule

// File: rtl/bcd_cal_clock_chk.sv
module bcd_cal_clock_chk
  import bcd_cal_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             load_i,
  input logic [IMG_W-1:0] load_data_i,
  input logic [IMG_W-1:0] regs_o
);
  logic halted;
  assign halted = regs_o[HALT_IMG_BIT];

  assert_load_image_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> regs_o == ($past(load_data_i) & IMG_MASK));

  assert_zero_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o & ~IMG_MASK) == '0);

  assert_load_over_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && tick_i) |=> regs_o[IDX_HUND*REG_W +: REG_W] ==
                           $past(load_data_i[IDX_HUND*REG_W +: REG_W]));

  assert_tick_advance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !halted) |=> regs_o != $past(regs_o));

  assert_mode_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(regs_o[IDX_HOUR*REG_W + HOUR_MODE_BIT]));

  assert_halt_freeze_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted && !load_i) |=> $stable(regs_o));

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(regs_o));
endmodule

bind bcd_cal_clock bcd_cal_clock_chk u_chk (.*);

// File: tb/sim_bcd_cal_clock.sv
module sim_bcd_cal_clock;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        load;
  logic [63:0] ld_data;
  logic [63:0] regs;

  int total = 0;
  int bad   = 0;

  // reference model, plain integers, hours kept 0..23 internally
  int m_hs, m_s, m_mi, m_hr, m_dow, m_dt, m_mo, m_yr;
  bit m_12, m_halt;

  always #10 clk = ~clk;

  bcd_cal_clock u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .load_i     (load),
    .load_data_i(ld_data),
    .regs_o     (regs)
  );

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] image();
    logic [7:0] hb;
    int h12;
    if (m_12) begin
      h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
      hb  = {1'b1, 1'b0, (m_hr >= 12), to_bcd(h12)[4:0]};
    end else begin
      hb = to_bcd(m_hr);
    end
    return {to_bcd(m_yr), to_bcd(m_mo), to_bcd(m_dt),
            {2'b00, m_halt, 2'b00, 3'(m_dow)},
            hb, to_bcd(m_mi), to_bcd(m_s), to_bcd(m_hs)};
  endfunction

  task automatic step_model();
    if (m_halt) return;
    m_hs++;
    if (m_hs < 100) return;
    m_hs = 0; m_s++;
    if (m_s < 60) return;
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr  = 0;
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    if (m_dt < mlen(m_mo, m_yr)) begin m_dt++; return; end
    m_dt = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1;
    m_yr = (m_yr + 1) % 100;
  endtask

  task automatic set_model(int hs, int s, int mi, int hr, bit h12, int dow,
                           int dt, int mo, int yr, bit halt);
    m_hs = hs; m_s = s; m_mi = mi; m_hr = hr; m_12 = h12;
    m_dow = dow; m_dt = dt; m_mo = mo; m_yr = yr; m_halt = halt;
  endtask

  task automatic check(string req, logic [63:0] exp);
    total++;
    if (regs !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, regs, exp);
    end
  endtask

  task automatic do_load(logic [63:0] v, bit with_tick);
    @(negedge clk);
    ld_data = v; load = 1'b1; tick = with_tick;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    step_model();
  endtask

  // load a state one hundredth before a carry, tick once, compare
  task automatic edge_case(string req, int hr, bit h12, int dow, int dt, int mo, int yr);
    set_model(99, 59, 59, hr, h12, dow, dt, mo, yr, 1'b0);
    do_load(image(), 1'b0);
    do_tick();
    check(req, image());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; load = 1'b0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    set_model(0, 0, 0, 0, 1'b0, 1, 1, 1, 0, 1'b0);
    check("R1 reset image", 64'h0001_0101_0000_0000);

    repeat (5) @(negedge clk);
    check("R12 idle hold", image());

    // R5: hundredths through a full minute plus
    for (int i = 0; i < 6100; i++) begin
      do_tick();
      check("R5 time carry", image());
    end

    // R6: every hour in 24-hour mode
    for (int h = 0; h < 24; h++) edge_case("R6 24h hours", h, 1'b0, 3, 15, 5, 7);
    // R7: every hour in 12-hour mode, PM at hours 12..23
    for (int h = 0; h < 24; h++) edge_case("R7 12h hours", h, 1'b1, 3, 15, 5, 7);
    // R8: each weekday wraps
    for (int d = 1; d <= 7; d++) edge_case("R8 day of week", 23, 1'b0, d, 10, 3, 11);
    // R9/R11: every month at its last day and the day before
    for (int mo = 1; mo <= 12; mo++) begin
      for (int y = 1; y <= 4; y += 3) begin
        edge_case("R9 month end", 23, 1'b0, 2, mlen(mo, y), mo, y);
        edge_case("R9 month not end", 23, 1'b0, 2, mlen(mo, y) - 1, mo, y);
      end
    end
    // R10: February across all two-digit years
    for (int y = 0; y < 100; y++) begin
      edge_case("R10 february 28", 23, 1'b0, 4, 28, 2, y);
      if (y % 4 == 0) edge_case("R10 february 29", 23, 1'b0, 4, 29, 2, y);
    end
    // R11: year rollover, 12-hour mode carry into the new year
    edge_case("R11 year wrap", 23, 1'b0, 7, 31, 12, 99);
    edge_case("R11 year wrap 12h", 23, 1'b1, 7, 31, 12, 98);

    // R3: all ones loaded, unused bits masked (halt bit set, so held)
    do_load(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    check("R3 zero bits", 64'hFF1F_3F27_BF7F_7FFF);
    do_tick();
    check("R12 halted after all-ones", 64'hFF1F_3F27_BF7F_7FFF);

    // R2: arbitrary valid image
    set_model(42, 17, 33, 19, 1'b0, 5, 22, 8, 63, 1'b0);
    do_load(image(), 1'b0);
    check("R2 load image", 64'h6308_2205_1933_1742);

    // R4: load coincides with tick
    set_model(99, 59, 59, 23, 1'b0, 1, 30, 6, 50, 1'b0);
    do_load(image(), 1'b1);
    check("R4 load over tick", image());

    // R12: halt freezes counting, clearing it resumes
    set_model(98, 59, 59, 23, 1'b0, 2, 28, 2, 21, 1'b1);
    do_load(image(), 1'b0);
    for (int i = 0; i < 5; i++) begin
      do_tick();
      check("R12 halt", image());
    end
    m_halt = 1'b0;
    do_load(image(), 1'b0);
    do_tick();
    do_tick();
    check("R12 resume", image());

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule